// File: doc/BRIEF.md
# I/O Translation Control Register Bank

This block is the software-visible register bank of an I/O address translation unit. A host writes and reads 32-bit words over a simple word-addressed register bus with an address, a write strobe, write data and a combinational read-data return. Each implemented register keeps only its defined bits and may also force some bits on. A page-table base, two flush command words, a group of per-slot configuration words and an arbitration-enable word are held beside the control word.

The control word carries the translation enable and a three-bit range code. On every control write the range code is decoded into the lowest address of the translated I/O window. That window start, together with the enable bit, is driven straight to the translation engine.

Word offsets that no register claims act as plain storage. They are held in a small associative store, so the bank needs no full-size memory behind a mostly empty map.

Top module: `ioxlat_csr`

## Requirements
- R1: After reset, the control word (word offset 0x000) reads 0x04000000, every other register and every unclaimed offset reads 0, `win_start` is 0x00000000 and `xlat_en` is 0.
- R2: A write to the control word stores (data & 0x0000001D) | 0x04000000. Bits 27:24 therefore always read back as 4.
- R3: On a control write, `win_start` takes, from the next cycle on, the decoded value of data bits 4:2. Code 0 gives 0xFF000000, 1 gives 0xFE000000, 2 gives 0xFC000000, 3 gives 0xF8000000, 4 gives 0xF0000000, 5 gives 0xE0000000, 6 gives 0xC0000000 and 7 gives 0x80000000. `win_start` changes at no other time.
- R4: `xlat_en` equals bit 0 of the stored control word.
- R5: A write to the page-table base (word offset 0x001) stores data & 0x07FFFC00.
- R6: The TLB flush word (word offset 0x005) and the page flush word (word offset 0x006) each store all 32 bits written.
- R7: The four slot configuration words (word offsets 0x404 to 0x407) each store data & 0x00010003 and are independent of one another. Bit 0 is bypass, bit 1 is 8-byte burst support and bit 16 is physical address bit 30 in bypass.
- R8: A write to the arbitration-enable word (word offset 0x800) stores (data & 0x001F0000) | 0x00000008.
- R9: A write to an unclaimed offset stores the full 32-bit value, and a later read of that offset returns it. An unclaimed offset that was never written reads 0.
- R10: Once all spare entries hold distinct offsets, a write to a further unclaimed offset is dropped and that offset still reads 0. Writes to offsets already held keep updating.
- R11: Reads have no side effects, and a cycle with the write strobe low changes no register, no `win_start` and no `xlat_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Word address of the access |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| win_start | output | 32 | Lowest address of the translated I/O window |
| xlat_en | output | 1 | Translation enable |

## Verification
The bench builds the bank with ADDR_W = 12, four slot words and SPARE_SLOTS = 4 instead of the default eight. With only four spare entries, a short directed sequence fills the associative store, which exposes the dropped-write case of R10 and the continued update of held entries. The twelve-bit address still covers every claimed offset, as well as unclaimed offsets next to the slot group and at the top of the map.

// File: rtl/ioxlat_csr_pkg.sv
package ioxlat_csr_pkg;

  // Word offsets of claimed registers (byte offset / 4)
  localparam logic [11:0] OFF_CTRL   = 12'h000;
  localparam logic [11:0] OFF_BASE   = 12'h001;
  localparam logic [11:0] OFF_TFLUSH = 12'h005;
  localparam logic [11:0] OFF_PFLUSH = 12'h006;
  localparam logic [11:0] OFF_SLOT0  = 12'h404;
  localparam logic [11:0] OFF_ARB    = 12'h800;

  localparam logic [31:0] CTRL_KEEP  = 32'h0000_001D;
  localparam logic [31:0] CTRL_FORCE = 32'h0400_0000;
  localparam logic [31:0] BASE_KEEP  = 32'h07FF_FC00;
  localparam logic [31:0] SLOT_KEEP  = 32'h0001_0003;
  localparam logic [31:0] ARB_KEEP   = 32'h001F_0000;
  localparam logic [31:0] ARB_FORCE  = 32'h0000_0008;

  typedef struct packed {
    logic ctrl;
    logic base;
    logic tflush;
    logic pflush;
    logic slot;
    logic arb;
    logic spare;
  } reg_sel_t;

  // Window start: all ones above the window size, 16 MB << code
  function automatic logic [31:0] win_start_of(input logic [2:0] code);
    return ~((32'h0100_0000 << code) - 32'd1);
  endfunction

  function automatic logic [31:0] shape_word(input logic [31:0] d,
                                             input logic [31:0] keep,
                                             input logic [31:0] force_on);
    return (d & keep) | force_on;
  endfunction

endpackage

// File: rtl/ioxlat_addr_dec.sv
module ioxlat_addr_dec
  import ioxlat_csr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned SLOT_CNT = 4,
  parameter int unsigned SIW      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic [SIW-1:0]    slot_idx
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_BASE   = ADDR_W'(OFF_BASE);
  localparam logic [ADDR_W-1:0] A_TFLUSH = ADDR_W'(OFF_TFLUSH);
  localparam logic [ADDR_W-1:0] A_PFLUSH = ADDR_W'(OFF_PFLUSH);
  localparam logic [ADDR_W-1:0] A_SLOT0  = ADDR_W'(OFF_SLOT0);
  localparam logic [ADDR_W-1:0] A_SLOTE  = ADDR_W'(OFF_SLOT0) + ADDR_W'(SLOT_CNT);
  localparam logic [ADDR_W-1:0] A_ARB    = ADDR_W'(OFF_ARB);

  logic [ADDR_W-1:0] slot_rel;

  always_comb begin
    slot_rel   = addr - A_SLOT0;
    sel.ctrl   = (addr == A_CTRL);
    sel.base   = (addr == A_BASE);
    sel.tflush = (addr == A_TFLUSH);
    sel.pflush = (addr == A_PFLUSH);
    sel.slot   = (addr >= A_SLOT0) && (addr < A_SLOTE);
    sel.arb    = (addr == A_ARB);
    sel.spare  = !(sel.ctrl || sel.base || sel.tflush || sel.pflush ||
                   sel.slot || sel.arb);
    slot_idx   = slot_rel[SIW-1:0];
  end

endmodule

// File: rtl/ioxlat_win_reg.sv
module ioxlat_win_reg
  import ioxlat_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [2:0]  code,
  output logic [31:0] win_start
);

  always_ff @(posedge clk) begin
    if (!rst_n)    win_start <= 32'h0;
    else if (load) win_start <= win_start_of(code);
  end

endmodule

// File: rtl/ioxlat_spare_store.sv
module ioxlat_spare_store #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SPARE_SLOTS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic [SPARE_SLOTS-1:0] hit
);

  logic [SPARE_SLOTS-1:0] valid_q;
  logic [ADDR_W-1:0]      tag_q  [SPARE_SLOTS];
  logic [31:0]            data_q [SPARE_SLOTS];
  logic [SPARE_SLOTS-1:0] free_pick;
  logic [SPARE_SLOTS-1:0] wr_slot;
  logic                   any_hit;

  always_comb begin
    logic found;
    found     = 1'b0;
    free_pick = '0;
    rdata     = 32'h0;
    for (int i = 0; i < SPARE_SLOTS; i++) begin
      hit[i] = valid_q[i] && (tag_q[i] == addr);
      if (hit[i]) rdata = rdata | data_q[i];
      if (!valid_q[i] && !found) begin
        free_pick[i] = 1'b1;
        found        = 1'b1;
      end
    end
    any_hit = |hit;
    wr_slot = wr_en ? (any_hit ? hit : free_pick) : '0;
  end

  for (genvar g = 0; g < SPARE_SLOTS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= 32'h0;
      end else if (wr_slot[g]) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= addr;
        data_q[g]  <= wdata;
      end
    end
  end

endmodule

// File: rtl/ioxlat_csr.sv
module ioxlat_csr
  import ioxlat_csr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SLOT_CNT    = 4,
  parameter int unsigned SPARE_SLOTS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [31:0]       win_start,
  output logic              xlat_en
);

  localparam int unsigned SIW = (SLOT_CNT > 1) ? $clog2(SLOT_CNT) : 1;

  reg_sel_t               sel;
  logic [SIW-1:0]         slot_idx;
  logic [31:0]            ctrl_q, base_q, tflush_q, pflush_q, arb_q;
  logic [31:0]            slot_q [SLOT_CNT];
  logic [31:0]            spare_rdata;
  logic [SPARE_SLOTS-1:0] spare_hit;

  // Named write events
  logic ctrl_wr, base_wr, tflush_wr, pflush_wr, slot_wr, arb_wr, spare_wr;

  ioxlat_addr_dec #(.ADDR_W(ADDR_W), .SLOT_CNT(SLOT_CNT), .SIW(SIW)) u_dec (
    .addr     (reg_addr),
    .sel      (sel),
    .slot_idx (slot_idx)
  );

  assign ctrl_wr   = reg_we && sel.ctrl;
  assign base_wr   = reg_we && sel.base;
  assign tflush_wr = reg_we && sel.tflush;
  assign pflush_wr = reg_we && sel.pflush;
  assign slot_wr   = reg_we && sel.slot;
  assign arb_wr    = reg_we && sel.arb;
  assign spare_wr  = reg_we && sel.spare;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_FORCE;
      base_q   <= 32'h0;
      tflush_q <= 32'h0;
      pflush_q <= 32'h0;
      arb_q    <= 32'h0;
    end else begin
      if (ctrl_wr)   ctrl_q   <= shape_word(reg_wdata, CTRL_KEEP, CTRL_FORCE);
      if (base_wr)   base_q   <= shape_word(reg_wdata, BASE_KEEP, 32'h0);
      if (tflush_wr) tflush_q <= reg_wdata;
      if (pflush_wr) pflush_q <= reg_wdata;
      if (arb_wr)    arb_q    <= shape_word(reg_wdata, ARB_KEEP, ARB_FORCE);
    end
  end

  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= 32'h0;
      else if (slot_wr && (slot_idx == SIW'(g)))
        slot_q[g] <= shape_word(reg_wdata, SLOT_KEEP, 32'h0);
    end
  end

  ioxlat_win_reg u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ctrl_wr),
    .code      (reg_wdata[4:2]),
    .win_start (win_start)
  );

  ioxlat_spare_store #(.ADDR_W(ADDR_W), .SPARE_SLOTS(SPARE_SLOTS)) u_spare (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (spare_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (spare_rdata),
    .hit   (spare_hit)
  );

  assign xlat_en = ctrl_q[0];

  always_comb begin
    if (sel.ctrl)        reg_rdata = ctrl_q;
    else if (sel.base)   reg_rdata = base_q;
    else if (sel.tflush) reg_rdata = tflush_q;
    else if (sel.pflush) reg_rdata = pflush_q;
    else if (sel.slot)   reg_rdata = slot_q[slot_idx];
    else if (sel.arb)    reg_rdata = arb_q;
    else                 reg_rdata = spare_rdata;
  end

endmodule

// File: rtl/ioxlat_csr_chk.sv
module ioxlat_csr_chk #(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SPARE_SLOTS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic                   reg_we,
  input logic [31:0]            reg_rdata,
  input logic [31:0]            win_start,
  input logic                   xlat_en,
  input logic                   ctrl_wr,
  input logic [SPARE_SLOTS-1:0] spare_hit
);

  // R2
  ctrl_version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(12'h000)) |-> ((reg_rdata & ~32'h0000_001D) == 32'h0400_0000));

  // R3
  win_only_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(win_start) |-> $past(ctrl_wr));

  // R3
  win_granule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_start[23:0] == 24'h0);

  // R4
  enable_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(12'h000)) |-> (reg_rdata[0] == xlat_en));

  // R5
  base_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(12'h001)) |-> ((reg_rdata & ~32'h07FF_FC00) == 32'h0));

  // R8
  arb_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(12'h800)) |-> ((reg_rdata & ~32'h001F_0008) == 32'h0));

  // R9
  spare_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(spare_hit));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(win_start) && $stable(xlat_en)));

endmodule

bind ioxlat_csr ioxlat_csr_chk #(.ADDR_W(ADDR_W), .SPARE_SLOTS(SPARE_SLOTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_rdata (reg_rdata),
  .win_start (win_start),
  .xlat_en   (xlat_en),
  .ctrl_wr   (ctrl_wr),
  .spare_hit (spare_hit)
);

// File: tb/ioxlat_csr_tb.sv
module ioxlat_csr_tb;

  localparam int unsigned ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_we = 1'b0;
  logic [31:0]       reg_wdata = 32'h0;
  logic [31:0]       reg_rdata;
  logic [31:0]       win_start;
  logic              xlat_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ioxlat_csr #(.ADDR_W(ADDR_W), .SLOT_CNT(4), .SPARE_SLOTS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .win_start(win_start), .xlat_en(xlat_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h000, v); check("R1 ctrl", v, 32'h0400_0000);
    rd(12'h001, v); check("R1 base", v, 32'h0);
    rd(12'h406, v); check("R1 slot2", v, 32'h0);
    rd(12'h800, v); check("R1 arb", v, 32'h0);
    rd(12'h123, v); check("R1 spare", v, 32'h0);
    check("R1 win_start", win_start, 32'h0);
    check("R1 xlat_en", {31'h0, xlat_en}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v, exp_win, d;
    for (int c = 0; c < 8; c++) begin
      logic [2:0] code = 3'(c);
      logic en = code[0];
      d = 32'hABCD_EFE2 | {27'h0, code, 1'b0, en};
      d[4:2] = code; d[0] = en;
      wr(12'h000, d);
      case (code)
        3'd0: exp_win = 32'hFF00_0000;
        3'd1: exp_win = 32'hFE00_0000;
        3'd2: exp_win = 32'hFC00_0000;
        3'd3: exp_win = 32'hF800_0000;
        3'd4: exp_win = 32'hF000_0000;
        3'd5: exp_win = 32'hE000_0000;
        3'd6: exp_win = 32'hC000_0000;
        default: exp_win = 32'h8000_0000;
      endcase
      #1;
      check("R3 window start", win_start, exp_win);
      check("R4 enable", {31'h0, xlat_en}, {31'h0, en});
      rd(12'h000, v);
      check("R2 ctrl readback", v, 32'h0400_0000 | {27'h0, code, 1'b0, en});
    end
  endtask

  task automatic t_base_flush();
    logic [31:0] v;
    wr(12'h001, 32'hFFFF_FFFF); rd(12'h001, v); check("R5 base ones", v, 32'h07FF_FC00);
    wr(12'h001, 32'h1234_5678); rd(12'h001, v); check("R5 base pattern", v, 32'h0234_5400);
    wr(12'h005, 32'hDEAD_BEEF); wr(12'h006, 32'h0F1E_2D3C);
    rd(12'h005, v); check("R6 tlb flush", v, 32'hDEAD_BEEF);
    rd(12'h006, v); check("R6 page flush", v, 32'h0F1E_2D3C);
  endtask

  task automatic t_slot();
    logic [31:0] v;
    wr(12'h404, 32'hFFFF_FFFF);
    wr(12'h405, 32'h0001_0002);
    wr(12'h406, 32'h0000_0001);
    wr(12'h407, 32'hFFFE_FFFC);
    rd(12'h404, v); check("R7 slot0", v, 32'h0001_0003);
    rd(12'h405, v); check("R7 slot1", v, 32'h0001_0002);
    rd(12'h406, v); check("R7 slot2", v, 32'h0000_0001);
    rd(12'h407, v); check("R7 slot3", v, 32'h0);
  endtask

  task automatic t_arb();
    logic [31:0] v;
    wr(12'h800, 32'hFFFF_FFFF); rd(12'h800, v); check("R8 arb ones", v, 32'h001F_0008);
    wr(12'h800, 32'h0000_0000); rd(12'h800, v); check("R8 arb zero", v, 32'h0000_0008);
  endtask

  task automatic t_spare();
    logic [31:0] v;
    wr(12'h002, 32'h1111_1111);
    wr(12'h408, 32'h2222_2222);
    wr(12'h100, 32'h3333_3333);
    wr(12'hBFF, 32'h4444_4444);
    rd(12'h002, v); check("R9 spare 002", v, 32'h1111_1111);
    rd(12'h408, v); check("R9 spare 408", v, 32'h2222_2222);
    rd(12'h100, v); check("R9 spare 100", v, 32'h3333_3333);
    rd(12'hBFF, v); check("R9 spare BFF", v, 32'h4444_4444);
    rd(12'h7FF, v); check("R9 never written", v, 32'h0);
    wr(12'h003, 32'h5555_5555);
    rd(12'h003, v); check("R10 dropped when full", v, 32'h0);
    wr(12'h100, 32'h6666_6666);
    rd(12'h100, v); check("R10 held entry updates", v, 32'h6666_6666);
    rd(12'h407, v); check("R9 slot untouched", v, 32'h0);
  endtask

  task automatic t_noside();
    logic [31:0] v, w0;
    wr(12'h000, 32'h0000_0009);
    w0 = win_start;
    @(negedge clk);
    reg_addr = 12'h000; reg_wdata = 32'hFFFF_FFFF; reg_we = 1'b0;
    @(negedge clk);
    #1;
    check("R11 win held", win_start, w0);
    check("R11 enable held", {31'h0, xlat_en}, 32'h1);
    rd(12'h000, v); check("R11 ctrl held", v, 32'h0400_0009);
    rd(12'h000, v); check("R11 repeat read", v, 32'h0400_0009);
    rd(12'h005, v); check("R11 flush held", v, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_base_flush();
    t_slot();
    t_arb();
    t_spare();
    t_noside();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule